// File: doc/BRIEF.md
# Two-Class Exception Entry and Return Controller

This block steers a processor core into and out of exception handlers. Each request line carries a class tag that marks it critical or noncritical. When a request is eligible, the controller records the interrupted program counter and machine-state word in a save/restore register pair that belongs to that class alone. It then issues a redirect to a handler address built from a software-set base and a per-source offset, together with a machine-state word that has the interrupt enables cleared. Two return strobes, one per class, redirect fetch to the saved address and restore the saved machine state from the matching pair.

Because the two classes never share storage, a critical exception can be taken inside a noncritical handler. The noncritical context that handler depends on is still there when the handler later returns. The core supplies the current PC and machine state every cycle. It applies the redirect in the cycle where `redir_valid` is high.

Top module: `exc_save_restore`

## Requirements
- R1: After reset, `redir_valid`, `ack`, `redir_pc` and `new_msw` are zero and both saved pairs hold zero, so a return strobe issued before any entry redirects to PC 0 with machine state 0.
- R2: Source i is critical when `exc_crit[i]` is 1 and noncritical when it is 0. An accepted request raises `redir_valid` and a one-hot `ack` with bit i set on the cycle after the request is sampled.
- R3: On entry, `redir_pc` equals `vec_base` in bits 31:8, with the source number times 8 in bits 7:0 (source 18 gives offset 0x90).
- R4: A noncritical entry stores `cur_pc` and `cur_msw` in the noncritical pair. Its `new_msw` is `cur_msw` with bit 15 (noncritical enable) cleared.
- R5: A critical entry stores `cur_pc` and `cur_msw` in the critical pair. Its `new_msw` is `cur_msw` with bit 15 and bit 17 (critical enable) both cleared.
- R6: An eligible critical request always wins over any noncritical request. Within one class, the lowest-numbered eligible source wins.
- R7: Noncritical requests are ignored while `cur_msw` bit 15 is 0, and critical requests are ignored while `cur_msw` bit 17 is 0. A request that is masked alone gives no redirect and no `ack`.
- R8: A `ret_nc` pulse redirects to the PC and machine state saved in the noncritical pair, and `ret_cr` does the same from the critical pair. Neither raises any `ack` bit.
- R9: A critical entry leaves the noncritical pair unchanged, so a later `ret_nc` still returns the context saved before the critical exception.
- R10: An accepted request in the same cycle as a return strobe takes the cycle, and the strobe is dropped. When both return strobes are high together, the critical return is taken.
- R11: A cycle with no eligible request and no return strobe leaves `redir_valid` and `ack` at zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exc_req | input | NSRC (19) | Exception request, one bit per source |
| exc_crit | input | NSRC (19) | Class tag per source, 1 = critical |
| cur_pc | input | PC_W (32) | Return address to save on entry |
| cur_msw | input | MSW_W (32) | Current machine state; bit 15 noncritical enable, bit 17 critical enable |
| vec_base | input | PC_W-8 (24) | Upper bits of every handler address |
| ret_nc | input | 1 | Return from a noncritical handler |
| ret_cr | input | 1 | Return from a critical handler |
| redir_valid | output | 1 | Fetch redirect this cycle |
| redir_pc | output | PC_W (32) | Redirect target |
| new_msw | output | MSW_W (32) | Machine state to load with the redirect |
| ack | output | NSRC (19) | One-hot acknowledge of the accepted source |

## Verification
Every result is registered once, so the redirect, acknowledge and new machine state that follow any input pattern show up exactly one clock after the edge that samples them. This holds whether the pattern is an entry, a return or an idle cycle. The driver applies one pattern per cycle on the falling edge and queues the outcome it expects. The monitor pops one item per rising edge, five nanoseconds after that edge, so each comparison lands on the cycle in which its result is due. Saved-pair contents are never read directly. They are observed through later return strobes, which makes nesting and masking visible at the ports.

// File: rtl/exc_sr_pkg.sv
package exc_sr_pkg;

  // One action is chosen per cycle; order here is descriptive only.
  typedef enum logic [2:0] {
    ACT_IDLE    = 3'd0,
    ACT_TAKE_NC = 3'd1,
    ACT_TAKE_CR = 3'd2,
    ACT_RET_NC  = 3'd3,
    ACT_RET_CR  = 3'd4
  } exc_act_e;

endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/exc_pick.sv
// Lowest-index selector over a candidate vector.
module exc_pick #(
  parameter int N     = 19,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     onehot
);

  always_comb begin
    found  = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found     = 1'b1;
        idx       = IDX_W'(i);
        onehot    = '0;
        onehot[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/exc_srr_pair.sv
// Save/restore register pair for one exception class.
module exc_srr_pair #(
  parameter int PC_W  = 32,
  parameter int MSW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PC_W-1:0]  d_pc,
  input  logic [MSW_W-1:0] d_msw,
  output logic [PC_W-1:0]  q_pc,
  output logic [MSW_W-1:0] q_msw
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_pc  <= '0;
      q_msw <= '0;
    end else if (load) begin
      q_pc  <= d_pc;
      q_msw <= d_msw;
    end
  end

endmodule

// File: rtl/exc_save_restore.sv
module exc_save_restore
  import exc_sr_pkg::*;
#(
  parameter int NSRC      = 19,
  parameter int PC_W      = 32,
  parameter int MSW_W     = 32,
  parameter int OFF_W     = 8,
  parameter int OFF_SHIFT = 3,
  parameter int NCE_BIT   = 15,
  parameter int CE_BIT    = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       exc_req,
  input  logic [NSRC-1:0]       exc_crit,
  input  logic [PC_W-1:0]       cur_pc,
  input  logic [MSW_W-1:0]      cur_msw,
  input  logic [PC_W-OFF_W-1:0] vec_base,
  input  logic                  ret_nc,
  input  logic                  ret_cr,
  output logic                  redir_valid,
  output logic [PC_W-1:0]       redir_pc,
  output logic [MSW_W-1:0]      new_msw,
  output logic [NSRC-1:0]       ack
);

  localparam int IDX_W  = $clog2(NSRC);
  localparam int NCLASS = 2;
  localparam int CL_NC  = 0;
  localparam int CL_CR  = 1;
  localparam logic [MSW_W-1:0] NCE_MASK = MSW_W'(1) << NCE_BIT;
  localparam logic [MSW_W-1:0] CE_MASK  = MSW_W'(1) << CE_BIT;

  logic rst_sync_n;

  exc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Per-class candidate vectors after class sort and enable masking.
  logic [NSRC-1:0]  cand  [NCLASS];
  logic             found [NCLASS];
  logic [IDX_W-1:0] idx   [NCLASS];
  logic [NSRC-1:0]  oh    [NCLASS];

  assign cand[CL_NC] = exc_req & ~exc_crit & {NSRC{cur_msw[NCE_BIT]}};
  assign cand[CL_CR] = exc_req &  exc_crit & {NSRC{cur_msw[CE_BIT]}};

  // Saved context per class.
  logic             srr_load  [NCLASS];
  logic [PC_W-1:0]  srr_pc    [NCLASS];
  logic [MSW_W-1:0] srr_msw   [NCLASS];

  for (genvar c = 0; c < NCLASS; c++) begin : g_class
    exc_pick #(
      .N     (NSRC),
      .IDX_W (IDX_W)
    ) u_pick (
      .cand   (cand[c]),
      .found  (found[c]),
      .idx    (idx[c]),
      .onehot (oh[c])
    );

    exc_srr_pair #(
      .PC_W  (PC_W),
      .MSW_W (MSW_W)
    ) u_pair (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .load  (srr_load[c]),
      .d_pc  (cur_pc),
      .d_msw (cur_msw),
      .q_pc  (srr_pc[c]),
      .q_msw (srr_msw[c])
    );
  end

  // Action selection: entries beat returns, critical beats noncritical.
  exc_act_e act;

  always_comb begin
    if (found[CL_CR]) begin
      act = ACT_TAKE_CR;
    end else if (found[CL_NC]) begin
      act = ACT_TAKE_NC;
    end else if (ret_cr) begin
      act = ACT_RET_CR;
    end else if (ret_nc) begin
      act = ACT_RET_NC;
    end else begin
      act = ACT_IDLE;
    end
  end

  assign srr_load[CL_NC] = (act == ACT_TAKE_NC);
  assign srr_load[CL_CR] = (act == ACT_TAKE_CR);

  logic [IDX_W-1:0] win_idx;
  logic [NSRC-1:0]  win_oh;
  logic [OFF_W-1:0] win_off;
  logic [PC_W-1:0]  vec_pc;

  assign win_idx = found[CL_CR] ? idx[CL_CR] : idx[CL_NC];
  assign win_oh  = found[CL_CR] ? oh[CL_CR]  : oh[CL_NC];
  assign win_off = OFF_W'(win_idx) << OFF_SHIFT;
  assign vec_pc  = {vec_base, win_off};

  // Next-state values for the output stage.
  logic             nx_valid;
  logic             out_en;
  logic [PC_W-1:0]  nx_pc;
  logic [MSW_W-1:0] nx_msw;
  logic [NSRC-1:0]  nx_ack;

  always_comb begin
    nx_valid = 1'b1;
    nx_pc    = redir_pc;
    nx_msw   = new_msw;
    nx_ack   = '0;
    unique case (act)
      ACT_TAKE_NC: begin
        nx_pc  = vec_pc;
        nx_msw = cur_msw & ~NCE_MASK;
        nx_ack = win_oh;
      end
      ACT_TAKE_CR: begin
        nx_pc  = vec_pc;
        nx_msw = cur_msw & ~(NCE_MASK | CE_MASK);
        nx_ack = win_oh;
      end
      ACT_RET_NC: begin
        nx_pc  = srr_pc[CL_NC];
        nx_msw = srr_msw[CL_NC];
      end
      ACT_RET_CR: begin
        nx_pc  = srr_pc[CL_CR];
        nx_msw = srr_msw[CL_CR];
      end
      default: begin
        nx_valid = 1'b0;
      end
    endcase
  end

  assign out_en = (act != ACT_IDLE);

  // Output registers: valid/ack every cycle, target only when enabled.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      redir_valid <= 1'b0;
      ack         <= '0;
    end else begin
      redir_valid <= nx_valid;
      ack         <= nx_ack;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      redir_pc <= '0;
      new_msw  <= '0;
    end else if (out_en) begin
      redir_pc <= nx_pc;
      new_msw  <= nx_msw;
    end
  end

endmodule

// File: rtl/exc_save_restore_chk.sv
module exc_save_restore_chk #(
  parameter int NSRC   = 19,
  parameter int BASE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   exc_req,
  input logic [NSRC-1:0]   exc_crit,
  input logic              cur_nce,
  input logic              cur_ce,
  input logic [BASE_W-1:0] vec_base,
  input logic              ret_nc,
  input logic              ret_cr,
  input logic              redir_valid,
  input logic [BASE_W-1:0] pc_hi,
  input logic              new_nce,
  input logic              new_ce,
  input logic [NSRC-1:0]   ack
);

  assert_ack_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_ack_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |-> redir_valid);

  assert_ack_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |-> ((ack & $past(exc_req)) == ack));

  assert_vec_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |-> (pc_hi == $past(vec_base)));

  assert_entry_nce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |-> !new_nce);

  assert_entry_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & $past(exc_crit))) |-> (!new_ce && !new_nce));

  assert_crit_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & ~$past(exc_crit))) |->
      ($past(exc_req & exc_crit & {NSRC{cur_ce}}) == '0));

  assert_nc_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & ~$past(exc_crit))) |-> $past(cur_nce));

  assert_cr_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & $past(exc_crit))) |-> $past(cur_ce));

  assert_ret_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !(|ack)) |-> $past(ret_nc || ret_cr));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past((|exc_req) || ret_nc || ret_cr));

endmodule

bind exc_save_restore exc_save_restore_chk #(
  .NSRC   (NSRC),
  .BASE_W (PC_W - OFF_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exc_req     (exc_req),
  .exc_crit    (exc_crit),
  .cur_nce     (cur_msw[NCE_BIT]),
  .cur_ce      (cur_msw[CE_BIT]),
  .vec_base    (vec_base),
  .ret_nc      (ret_nc),
  .ret_cr      (ret_cr),
  .redir_valid (redir_valid),
  .pc_hi       (redir_pc[PC_W-1:OFF_W]),
  .new_nce     (new_msw[NCE_BIT]),
  .new_ce      (new_msw[CE_BIT]),
  .ack         (ack)
);

// File: tb/exc_save_restore_test.sv
module exc_save_restore_test;

  localparam int N = 19;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  exc_req;
  logic [N-1:0]  exc_crit;
  logic [31:0]   cur_pc;
  logic [31:0]   cur_msw;
  logic [23:0]   vec_base;
  logic          ret_nc;
  logic          ret_cr;
  logic          redir_valid;
  logic [31:0]   redir_pc;
  logic [31:0]   new_msw;
  logic [N-1:0]  ack;

  exc_save_restore uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_req     (exc_req),
    .exc_crit    (exc_crit),
    .cur_pc      (cur_pc),
    .cur_msw     (cur_msw),
    .vec_base    (vec_base),
    .ret_nc      (ret_nc),
    .ret_cr      (ret_cr),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .new_msw     (new_msw),
    .ack         (ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic         v;
    logic [31:0]  pc;
    logic [31:0]  msw;
    logic [N-1:0] ack;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;

  // Bench-side model of the two saved pairs.
  logic [31:0] m_nc_pc, m_nc_msw, m_cr_pc, m_cr_msw;

  localparam logic [31:0] EN_BOTH = 32'h0002_8000; // bit 17 and bit 15
  localparam logic [31:0] EN_CE   = 32'h0002_0000;
  localparam logic [31:0] EN_NCE  = 32'h0000_8000;

  task automatic step(input logic [N-1:0] req, input logic [N-1:0] crit,
                      input logic [31:0] pc, input logic [31:0] msw,
                      input logic [23:0] base, input logic rnc,
                      input logic rcr, input string tag);
    logic [N-1:0] crc, ncc;
    int   ci, ni;
    exp_t e;
    @(negedge clk);
    exc_req = req; exc_crit = crit; cur_pc = pc; cur_msw = msw;
    vec_base = base; ret_nc = rnc; ret_cr = rcr;
    crc = req & crit & {N{msw[17]}};
    ncc = req & ~crit & {N{msw[15]}};
    ci = -1; ni = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (crc[i]) ci = i;
      if (ncc[i]) ni = i;
    end
    e = '0;
    if (ci >= 0) begin
      e.v = 1'b1; e.pc = {base, 8'(ci * 8)};
      e.msw = msw & ~(EN_BOTH); e.ack[ci] = 1'b1;
      m_cr_pc = pc; m_cr_msw = msw;
    end else if (ni >= 0) begin
      e.v = 1'b1; e.pc = {base, 8'(ni * 8)};
      e.msw = msw & ~EN_NCE; e.ack[ni] = 1'b1;
      m_nc_pc = pc; m_nc_msw = msw;
    end else if (rcr) begin
      e.v = 1'b1; e.pc = m_cr_pc; e.msw = m_cr_msw;
    end else if (rnc) begin
      e.v = 1'b1; e.pc = m_nc_pc; e.msw = m_nc_msw;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: one expected item per rising edge, sampled 5 ns later.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        logic  bad;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        bad = (redir_valid !== e.v) || (ack !== e.ack);
        if (e.v) bad = bad || (redir_pc !== e.pc) || (new_msw !== e.msw);
        if (bad) begin
          n_fail++;
          $display("FAIL %s: got v=%0b pc=%h msw=%h ack=%h, expected v=%0b pc=%h msw=%h ack=%h",
                   t, redir_valid, redir_pc, new_msw, ack, e.v, e.pc, e.msw, e.ack);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_nc_pc = '0; m_nc_msw = '0; m_cr_pc = '0; m_cr_msw = '0;
    rst_n = 1'b0; exc_req = '0; exc_crit = '0; cur_pc = '0; cur_msw = '0;
    vec_base = '0; ret_nc = 1'b0; ret_cr = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    n_tests++;
    if (redir_valid !== 1'b0 || ack !== '0 || redir_pc !== '0 || new_msw !== '0) begin
      n_fail++;
      $display("FAIL R1: got v=%0b pc=%h msw=%h ack=%h, expected all zero",
               redir_valid, redir_pc, new_msw, ack);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: return before any entry lands on zero context
    step('0, '0, 32'h0, EN_BOTH, 24'h0, 1'b1, 1'b0, "R1");
    // R4/R3: noncritical entry from source 3
    step(19'h8, '0, 32'h0000_1000, EN_BOTH | 32'h5, 24'hABCDEF, 1'b0, 1'b0, "R4");
    // R11: idle cycle
    step('0, '0, 32'h0, EN_BOTH, 24'hABCDEF, 1'b0, 1'b0, "R11");
    // R5/R9: critical entry from source 7 inside the noncritical handler
    step(19'h80, 19'h80, 32'h0000_2000, EN_CE | 32'h30, 24'h123456, 1'b0, 1'b0, "R5");
    // R8: critical return
    step('0, '0, 32'h0, 32'h0, 24'h0, 1'b0, 1'b1, "R8");
    // R9: noncritical pair survived the critical entry
    step('0, '0, 32'h0, 32'h0, 24'h0, 1'b1, 1'b0, "R9");
    // R6: critical over noncritical, lowest critical index
    step(19'h224, 19'h220, 32'h0000_3000, EN_BOTH, 24'h00F00F, 1'b0, 1'b0, "R6");
    // R6: lowest index within noncritical class
    step(19'h810, '0, 32'h0000_4000, EN_BOTH, 24'h00F00F, 1'b0, 1'b0, "R6");
    // R7: noncritical masked
    step(19'h2, '0, 32'h0000_5000, EN_CE, 24'h1, 1'b0, 1'b0, "R7");
    // R7: critical masked
    step(19'h2, 19'h2, 32'h0000_5000, EN_NCE, 24'h1, 1'b0, 1'b0, "R7");
    // R7: masked critical does not block eligible noncritical
    step(19'h6, 19'h2, 32'h0000_6000, EN_NCE, 24'h2, 1'b0, 1'b0, "R7");
    // R10: entry beats return strobe in same cycle
    step(19'h1, '0, 32'h0000_7000, EN_BOTH, 24'h3, 1'b1, 1'b1, "R10");
    // R10: both returns -> critical pair
    step('0, '0, 32'h0, 32'h0, 24'h0, 1'b1, 1'b1, "R10");
    // R3/R2: highest source, critical, offset 0x90
    step(19'h40000, 19'h40000, 32'h0000_8000, EN_BOTH, 24'hFEDCBA, 1'b0, 1'b0, "R3");
    // R2: source 0 noncritical
    step(19'h1, '0, 32'h0000_9000, EN_BOTH, 24'h77, 1'b0, 1'b0, "R2");
    // R8: noncritical return after new entry
    step('0, '0, 32'h0, 32'h0, 24'h0, 1'b1, 1'b0, "R8");

    @(negedge clk);
    exc_req = '0; ret_nc = 1'b0; ret_cr = 1'b0;
    repeat (3) @(posedge clk);
    #6;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: got %0d unconsumed results, expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule